// File: doc/BRIEF.md
# Flash Command Sequencer with Strap Lockout

This block watches the write strobes that a host applies to a flash device and recognises two kinds of command: the six-write sector-erase sequence, and the sequences that move the device into and out of product-identification mode. When an erase command completes, the block checks the target sector against hardware and software protection. It then issues either a one-cycle erase request carrying the sector number, or a one-cycle blocked indication. Any write that does not fit the sequence in progress sends the decoder back to idle, and that write causes no action.

Two strap pins give hardware protection. The boot strap guards the top boot sector. The write-protect strap guards every other sector. Both are sampled while reset is held and are kept fixed after reset is released. A software boot-lock input can also protect the boot sector, but only while the boot strap leaves that sector open.

In identification mode, a read of one fixed address is overridden with a status byte. That byte reports the two latched straps in inverted form, so a bit reads 1 when the matching strap is low and the protection is active. The array timing and the bus framing are handled outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the following edge leaves erase_req and blocked low and identification mode off, so rd_ovr_vld stays 0.
- R2: The writes AA@0x05555, 55@0x02AAA, 80@0x05555, AA@0x05555, 55@0x02AAA, then 0x30 at any address make up an erase command. The clock edge that samples the last write either raises erase_req for exactly one cycle, with erase_sector equal to that write's address bits [18:16], or raises blocked instead.
- R3: A write that does not match the next expected step returns the decoder to idle with no erase_req and no blocked. A following 0x30 write then has no effect.
- R4: When the boot strap was low at reset, an erase of sector 7 gives blocked for one cycle and no erase_req, whatever the value of sw_boot_lock.
- R5: When the boot strap was high at reset, an erase of sector 7 is blocked exactly when sw_boot_lock is 1 at the final write. sw_boot_lock has no effect on sectors 0 to 6.
- R6: When the write-protect strap was low at reset, an erase of any of sectors 0 to 6 is blocked. Sector 7 is not affected by this strap.
- R7: The straps are sampled only while rst_n is low. A change on a strap pin after reset is released has no effect on protection or on readback.
- R8: The writes AA@0x05555, 55@0x02AAA, 90@0x05555 enter identification mode. While the mode is active and rd_addr is 0x7FFF2, rd_ovr_vld is 1 and rd_ovr_data is 0 except bit 2, which is the inverse of the latched boot strap, and bit 3, which is the inverse of the latched write-protect strap. At any other address, or when the mode is off, rd_ovr_vld and rd_ovr_data are 0.
- R9: The three writes AA@0x05555, 55@0x02AAA, F0@0x05555 leave identification mode. The mode stays active after only the first two of those writes.
- R10: A single write of 0xF0 at any address leaves identification mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| boot_strap_n | input | 1 | Boot-sector strap; low locks sector 7 |
| wp_strap_n | input | 1 | Write-protect strap; low locks sectors 0 to 6 |
| sw_boot_lock | input | 1 | Software lock for the boot sector |
| rd_addr | input | 19 | Address of the current read |
| rd_ovr_vld | output | 1 | Read data is overridden by the status byte |
| rd_ovr_data | output | 8 | Status byte for the identification address |
| erase_req | output | 1 | One-cycle request to erase a sector |
| erase_sector | output | 3 | Sector number that goes with erase_req |
| blocked | output | 1 | One-cycle flag: the erase target is protected |

## Verification
The bench builds the block with its default parameters: a 19-bit address and eight 64 KB sectors, with the boot sector at index 7. This places the identification address 0x7FFF2 inside the boot sector and gives the protection logic a single, distinct top sector to separate from the rest. The bench applies reset several times with different strap levels, so each combination of strap and software lock can be reached. It also drives the strap pins after reset is released to show that the latched values do not change.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, unlock addresses and decoder state type for the
// flash command sequencer. Assumes a 19-bit byte address space.
package flash_cmd_pkg;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_ERASE    = 8'h30;
    localparam logic [7:0] CMD_ID_ENTER = 8'h90;
    localparam logic [7:0] CMD_ID_EXIT  = 8'hF0;

    localparam logic [18:0] ADDR_KEY_A  = 19'h05555;
    localparam logic [18:0] ADDR_KEY_B  = 19'h02AAA;
    localparam logic [18:0] ADDR_STATUS = 19'h7FFF2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_ARMED,
        SQ_KEY4,
        SQ_KEY5
    } seq_state_t;

endpackage

// File: rtl/strap_latch.sv
// Samples the two strap pins while reset is held and keeps them fixed after
// release. Outputs are active-high "locked" flags, which are the inverse of
// the pins. Assumes the straps are stable for at least one edge in reset.
module strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_strap_n,
    input  logic wp_strap_n,
    output logic boot_lk_q,
    output logic wp_lk_q
);

    // Capture the inverted straps during reset, then hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_lk_q <= ~boot_strap_n;
            wp_lk_q   <= ~wp_strap_n;
        end
    end

endmodule

// File: rtl/cmd_decoder.sv
// Tracks the write sequence. It signals a completed erase command in the
// cycle of the final write and holds the identification-mode flag. Any
// write that does not fit the expected step returns the decoder to idle.
// An F0 write always leaves identification mode.
module cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              erase_hit,
    output logic [SECT_W-1:0] hit_sector,
    output logic              id_active
);

    seq_state_t state, state_nx;
    logic       id_nx;
    logic       at_key_a, at_key_b;

    assign at_key_a   = (wr_addr == ADDR_W'(ADDR_KEY_A));
    assign at_key_b   = (wr_addr == ADDR_W'(ADDR_KEY_B));
    assign hit_sector = wr_addr[ADDR_W-1 -: SECT_W];

    // Next-state decode for one write.
    always_comb begin
        state_nx  = state;
        id_nx     = id_active;
        erase_hit = 1'b0;
        if (wr_en) begin
            state_nx = SQ_IDLE;
            if (wr_data == CMD_ID_EXIT) begin
                id_nx = 1'b0;
            end else begin
                case (state)
                    SQ_IDLE:  if (at_key_a && wr_data == CMD_UNLOCK_A) state_nx = SQ_KEY1;
                    SQ_KEY1:  if (at_key_b && wr_data == CMD_UNLOCK_B) state_nx = SQ_KEY2;
                    SQ_KEY2: begin
                        if (at_key_a && wr_data == CMD_SETUP)
                            state_nx = SQ_ARMED;
                        else if (at_key_a && wr_data == CMD_ID_ENTER)
                            id_nx = 1'b1;
                    end
                    SQ_ARMED: if (at_key_a && wr_data == CMD_UNLOCK_A) state_nx = SQ_KEY4;
                    SQ_KEY4:  if (at_key_b && wr_data == CMD_UNLOCK_B) state_nx = SQ_KEY5;
                    SQ_KEY5:  erase_hit = (wr_data == CMD_ERASE);
                    default:  state_nx = SQ_IDLE;
                endcase
            end
        end
    end

    // State and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            id_active <= 1'b0;
        end else begin
            state     <= state_nx;
            id_active <= id_nx;
        end
    end

endmodule

// File: rtl/protect_gate.sv
// Checks a completed erase command against the strap and software locks.
// It issues either a registered erase pulse or a blocked pulse.
// The top sector is the boot sector.
module protect_gate #(
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_hit,
    input  logic [SECT_W-1:0] hit_sector,
    input  logic              boot_lk_q,
    input  logic              wp_lk_q,
    input  logic              sw_boot_lock,
    output logic              erase_req,
    output logic [SECT_W-1:0] erase_sector,
    output logic              blocked
);

    localparam logic [SECT_W-1:0] BOOT_SECT = SECT_W'((1 << SECT_W) - 1);

    logic is_boot, denied;

    assign is_boot = (hit_sector == BOOT_SECT);
    assign denied  = is_boot ? (boot_lk_q | sw_boot_lock) : wp_lk_q;

    // Register the outcome as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req    <= 1'b0;
            blocked      <= 1'b0;
            erase_sector <= '0;
        end else begin
            erase_req <= erase_hit & ~denied;
            blocked   <= erase_hit & denied;
            if (erase_hit) erase_sector <= hit_sector;
        end
    end

endmodule

// File: rtl/id_readback.sv
// Overrides a read of the status address while identification mode is active.
// Bit 2 carries the boot-lock flag and bit 3 the write-protect flag.
module id_readback
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              id_active,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              boot_lk_q,
    input  logic              wp_lk_q,
    output logic              rd_ovr_vld,
    output logic [7:0]        rd_ovr_data
);

    // Form the status byte for a matching read.
    always_comb begin
        rd_ovr_vld  = id_active && (rd_addr == ADDR_W'(ADDR_STATUS));
        rd_ovr_data = 8'h00;
        if (rd_ovr_vld) rd_ovr_data = {4'b0000, wp_lk_q, boot_lk_q, 2'b00};
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Top level of the flash command sequencer. It connects the strap latch,
// the sequence decoder, the protection gate and the status readback.
// Assumes wr_en is a one-cycle strobe per bus write.
module flash_cmd_seq #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              boot_strap_n,
    input  logic              wp_strap_n,
    input  logic              sw_boot_lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ovr_vld,
    output logic [7:0]        rd_ovr_data,
    output logic              erase_req,
    output logic [SECT_W-1:0] erase_sector,
    output logic              blocked
);

    logic              boot_lk_q, wp_lk_q;
    logic              erase_hit, id_active;
    logic [SECT_W-1:0] hit_sector;

    strap_latch u_straps (
        .clk(clk), .rst_n(rst_n),
        .boot_strap_n(boot_strap_n), .wp_strap_n(wp_strap_n),
        .boot_lk_q(boot_lk_q), .wp_lk_q(wp_lk_q)
    );

    cmd_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_hit(erase_hit), .hit_sector(hit_sector), .id_active(id_active)
    );

    protect_gate #(.SECT_W(SECT_W)) u_prot (
        .clk(clk), .rst_n(rst_n),
        .erase_hit(erase_hit), .hit_sector(hit_sector),
        .boot_lk_q(boot_lk_q), .wp_lk_q(wp_lk_q), .sw_boot_lock(sw_boot_lock),
        .erase_req(erase_req), .erase_sector(erase_sector), .blocked(blocked)
    );

    id_readback #(.ADDR_W(ADDR_W)) u_rdbk (
        .id_active(id_active), .rd_addr(rd_addr),
        .boot_lk_q(boot_lk_q), .wp_lk_q(wp_lk_q),
        .rd_ovr_vld(rd_ovr_vld), .rd_ovr_data(rd_ovr_data)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Assertion checker for flash_cmd_seq. It is attached by bind and observes
// the ports and the latched strap and mode state.
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              sw_boot_lock,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ovr_vld,
    input logic              erase_req,
    input logic [SECT_W-1:0] erase_sector,
    input logic              blocked,
    input logic              boot_lk_q,
    input logic              wp_lk_q,
    input logic              id_active
);

    localparam logic [SECT_W-1:0] BOOT_SECT = SECT_W'((1 << SECT_W) - 1);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(19'h7FFF2);

    // R1: a reset edge clears the pulses and the mode.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!erase_req && !blocked && !id_active));

    // R2: an erase pulse follows a 0x30 write and carries its sector.
    p_erase_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(wr_en) && $past(wr_data) == 8'h30
                       && erase_sector == $past(wr_addr[ADDR_W-1 -: SECT_W])));

    // R2: the erase pulse lasts one cycle.
    p_erase_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R4: request and blocked never appear together.
    p_req_blk_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_req && blocked));

    // R5: the boot sector is erased only when both locks are clear.
    p_boot_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_sector == BOOT_SECT) |-> (!boot_lk_q && !$past(sw_boot_lock)));

    // R6: other sectors are erased only when the write-protect strap is high.
    p_other_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_sector != BOOT_SECT) |-> !wp_lk_q);

    // R7: the latched straps stay fixed once out of reset.
    p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(boot_lk_q) && $stable(wp_lk_q)));

    // R8: the override appears only in the mode and at the status address.
    p_ovr_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovr_vld |-> (id_active && rd_addr == STAT_ADDR));

    // R10: an F0 write always leaves identification mode.
    p_exit_f0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'hF0) |=> !id_active);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_boot_lock(sw_boot_lock), .rd_addr(rd_addr), .rd_ovr_vld(rd_ovr_vld),
    .erase_req(erase_req), .erase_sector(erase_sector), .blocked(blocked),
    .boot_lk_q(boot_lk_q), .wp_lk_q(wp_lk_q), .id_active(id_active)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [18:0] a;
        logic [7:0]  d;
        logic        req;
        logic        blk;
        logic [2:0]  sec;
        logic [3:0]  rq;
    } vec_t;

    // Main walk: straps high, software lock clear (R2 sequences, R3 breaks).
    localparam vec_t VEC [NV] = '{
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h02AAA, 8'h55, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h05555, 8'h80, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h02AAA, 8'h55, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h31234, 8'h30, 1'b1, 1'b0, 3'd3, 4'd2},
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h02AAA, 8'h55, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h05555, 8'h80, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h02AAA, 8'h12, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h10000, 8'h30, 1'b0, 1'b0, 3'd0, 4'd3},
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h02AAA, 8'h55, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h05555, 8'h80, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h05555, 8'hAA, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h02AAA, 8'h55, 1'b0, 1'b0, 3'd0, 4'd2},
        '{19'h7ABCD, 8'h30, 1'b1, 1'b0, 3'd7, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        boot_strap_n = 1'b1;
    logic        wp_strap_n = 1'b1;
    logic        sw_boot_lock = 1'b0;
    logic [18:0] rd_addr = '0;
    logic        rd_ovr_vld;
    logic [7:0]  rd_ovr_data;
    logic        erase_req;
    logic [2:0]  erase_sector;
    logic        blocked;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .boot_strap_n(boot_strap_n), .wp_strap_n(wp_strap_n), .sw_boot_lock(sw_boot_lock),
        .rd_addr(rd_addr), .rd_ovr_vld(rd_ovr_vld), .rd_ovr_data(rd_ovr_data),
        .erase_req(erase_req), .erase_sector(erase_sector), .blocked(blocked)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Apply reset with the given strap levels, then release.
    task automatic do_reset(input logic bs, input logic wp);
        @(negedge clk);
        rst_n = 1'b0; boot_strap_n = bs; wp_strap_n = wp;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; returns outputs one edge later, strobe dropped afterwards.
    task automatic wr(input logic [18:0] a, input logic [7:0] d,
                      output logic req, output logic blk, output logic [2:0] sec);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        req = erase_req; blk = blocked; sec = erase_sector;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic erase(input logic [2:0] s, output logic req, output logic blk,
                         output logic [2:0] sec);
        logic r, b; logic [2:0] x;
        wr(19'h05555, 8'hAA, r, b, x);
        wr(19'h02AAA, 8'h55, r, b, x);
        wr(19'h05555, 8'h80, r, b, x);
        wr(19'h05555, 8'hAA, r, b, x);
        wr(19'h02AAA, 8'h55, r, b, x);
        wr({s, 16'h0040}, 8'h30, req, blk, sec);
    endtask

    task automatic id_enter();
        logic r, b; logic [2:0] x;
        wr(19'h05555, 8'hAA, r, b, x);
        wr(19'h02AAA, 8'h55, r, b, x);
        wr(19'h05555, 8'h90, r, b, x);
    endtask

    task automatic read_chk(input string tag, input logic [18:0] a,
                            input logic ev, input logic [7:0] ed);
        @(negedge clk);
        rd_addr = a;
        #1;
        check({tag, " rd_ovr_vld"}, 16'(rd_ovr_vld), 16'(ev));
        check({tag, " rd_ovr_data"}, 16'(rd_ovr_data), 16'(ed));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic r, b; logic [2:0] s;

        // R1: reset state
        do_reset(1'b1, 1'b1);
        #1;
        check("R1 erase_req", 16'(erase_req), 16'd0);
        check("R1 blocked", 16'(blocked), 16'd0);
        read_chk("R1", 19'h7FFF2, 1'b0, 8'h00);

        // R2 and R3: table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].d, r, b, s);
            n_checks++;
            if (r !== VEC[i].req || b !== VEC[i].blk || (VEC[i].req && s !== VEC[i].sec)) begin
                n_fail++;
                $display("FAIL R%0d row %0d actual=%b/%b/%0d expected=%b/%b/%0d",
                         VEC[i].rq, i, r, b, s, VEC[i].req, VEC[i].blk, VEC[i].sec);
            end
        end
        // R2: pulse drops after one cycle
        @(posedge clk); #1;
        check("R2 pulse width", 16'(erase_req), 16'd0);

        // R5: software lock on boot sector only
        sw_boot_lock = 1'b1;
        erase(3'd7, r, b, s);
        check("R5 boot sw-locked req", 16'(r), 16'd0);
        check("R5 boot sw-locked blk", 16'(b), 16'd1);
        erase(3'd2, r, b, s);
        check("R5 other sector req", 16'(r), 16'd1);
        check("R5 other sector num", 16'(s), 16'd2);

        // R4: boot strap low locks sector 7 regardless of software
        do_reset(1'b0, 1'b1);
        sw_boot_lock = 1'b0;
        erase(3'd7, r, b, s);
        check("R4 boot strap req", 16'(r), 16'd0);
        check("R4 boot strap blk", 16'(b), 16'd1);
        @(posedge clk); #1;
        check("R4 blk pulse width", 16'(blocked), 16'd0);
        erase(3'd0, r, b, s);
        check("R4 sector0 req", 16'(r), 16'd1);

        // R6: write-protect strap low locks sectors 0..6
        do_reset(1'b1, 1'b0);
        erase(3'd4, r, b, s);
        check("R6 wp sector4 blk", 16'(b), 16'd1);
        check("R6 wp sector4 req", 16'(r), 16'd0);
        erase(3'd7, r, b, s);
        check("R6 boot unaffected req", 16'(r), 16'd1);

        // R7: strap changes after reset ignored
        @(negedge clk);
        wp_strap_n = 1'b1; boot_strap_n = 1'b0;
        erase(3'd4, r, b, s);
        check("R7 wp held blk", 16'(b), 16'd1);
        erase(3'd7, r, b, s);
        check("R7 boot held req", 16'(r), 16'd1);

        // R8: readback reflects latched straps (boot high, wp low)
        id_enter();
        read_chk("R7/R8 status", 19'h7FFF2, 1'b1, 8'h08);
        read_chk("R8 other addr", 19'h7FFF3, 1'b0, 8'h00);

        // R10: single F0 anywhere exits
        wr(19'h00123, 8'hF0, r, b, s);
        read_chk("R10 exit", 19'h7FFF2, 1'b0, 8'h00);

        // R8: both straps low
        do_reset(1'b0, 1'b0);
        id_enter();
        read_chk("R8 both low", 19'h7FFF2, 1'b1, 8'h0C);

        // R9: three-write exit
        wr(19'h05555, 8'hAA, r, b, s);
        wr(19'h02AAA, 8'h55, r, b, s);
        read_chk("R9 still in mode", 19'h7FFF2, 1'b1, 8'h0C);
        wr(19'h05555, 8'hF0, r, b, s);
        read_chk("R9 exit", 19'h7FFF2, 1'b0, 8'h00);

        // R1: reset clears identification mode
        id_enter();
        do_reset(1'b1, 1'b1);
        read_chk("R1 reset clears mode", 19'h7FFF2, 1'b0, 8'h00);

        finish_run();
    end

endmodule